// File: doc/BRIEF.md
# Dual-output level interrupt controller

This controller gathers a vector of level-sensitive interrupt lines and drives two request outputs: a normal request and a fast request. Each output has its own enable mask. A line's raw bit is high while the line is high. Raw bit 0 can also be driven by a software flag that is set and cleared through the register port. An output is high whenever any raw bit is also enabled for that output. Several controllers can be cascaded: the normal output of one controller is wired to an input line of another.

Software reaches the controller through a word-indexed register port. A request is presented for one cycle with an index, a write flag and write data. Read data and an access-error flag come back on the next cycle. Each enable mask is updated through a set-only index and a clear-only index, so several agents can share a mask without a read-modify-write sequence. Priority, vectoring and edge detection are not part of the block.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset both enable masks and the soft flag are zero, both request outputs are low, and `rdata_o` and `err_o` are zero.
- R2: The raw vector is the line levels captured at each clock edge, with bit 0 ORed with the soft flag. A read of index 1 or index 9 returns the raw vector.
- R3: A write to index 2 ORs the write data into the normal mask. A read of index 2 returns the normal mask.
- R4: A write to index 3 clears each normal-mask bit that is 1 in the write data and leaves the other bits unchanged.
- R5: A write to index 4 with data bit 0 set raises the soft flag. A write to index 5 with data bit 0 set clears it. The other data bits have no effect. A read of index 4 returns raw bit 0 in bit 0 and zeros in bits 31:1.
- R6: A write to index 10 ORs the write data into the fast mask, and a read of index 10 returns that mask. A write to index 11 clears the fast-mask bits that are 1 in the write data.
- R7: A read of index 0 returns the raw vector ANDed with the normal mask. A read of index 8 returns the raw vector ANDed with the fast mask.
- R8: `irq_o` is registered. After each clock edge it equals the OR-reduction of (raw vector AND normal mask), using the line levels and register writes taken at that edge.
- R9: `fiq_o` is registered. After each clock edge it equals the OR-reduction of (raw vector AND fast mask), using the line levels and register writes taken at that edge.
- R10: A read of a clear-only index (3, 5, 11) returns zero and raises `err_o`. A write to a status index (0, 1, 8, 9) changes no state and raises `err_o`. Indices 6, 7 and 12 to 15 raise `err_o` on both reads and writes, read as zero and change nothing.
- R11: The soft flag and input line 0 are ORed, so either one alone holds raw bit 0 high.
- R12: `rdata_o` and `err_o` are valid in the cycle after the request. They are zero in a cycle that follows no request. `rdata_o` is zero after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lines_i | input | N_LINES | Level interrupt inputs |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| idx_i | input | 4 | Word index of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, one cycle after the request |
| err_o | output | 1 | Access error, one cycle after the request |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Every result is due exactly one rising edge after its cause. Read data and the error flag follow the request cycle. Both request outputs follow the edge at which a line level is captured or a mask or soft-flag write is applied, so there is no extra cycle through the raw register. The bench drives stimulus on falling edges and advances its reference model on rising edges. It compares all four outputs at every following falling edge, so an output that is one cycle early or late shows up as a mismatch. The sequence steps through each index in both directions, holds line 0 and the soft flag in overlapping patterns, and ends with a long stretch of random traffic.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int IDX_W = 4;
  localparam int N_OUT = 2;  // 0: normal, 1: fast

  typedef enum logic [IDX_W-1:0] {
    IX_IRQ_STAT = 4'd0,
    IX_IRQ_RAW  = 4'd1,
    IX_IRQ_ENS  = 4'd2,
    IX_IRQ_ENC  = 4'd3,
    IX_SOFT_SET = 4'd4,
    IX_SOFT_CLR = 4'd5,
    IX_FIQ_STAT = 4'd8,
    IX_FIQ_RAW  = 4'd9,
    IX_FIQ_ENS  = 4'd10,
    IX_FIQ_ENC  = 4'd11
  } reg_idx_e;
endpackage

// File: rtl/dic_capture.sv
module dic_capture #(
  parameter int N_LINES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] line_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q_o <= '0;
    else         line_q_o <= lines_i;
  end
endmodule

// File: rtl/dic_regs.sv
module dic_regs
  import dic_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [N_LINES-1:0] raw_q_i,
  output logic [N_LINES-1:0] ien_q_o,
  output logic [N_LINES-1:0] fen_q_o,
  output logic [N_LINES-1:0] ien_d_o,
  output logic [N_LINES-1:0] fen_d_o,
  output logic               soft_q_o,
  output logic               soft_d_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o
);
  logic               wr, rd;
  logic [N_LINES-1:0] wmask;
  logic [DATA_W-1:0]  rd_val;
  logic               rd_bad, wr_bad;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wmask = wdata_i[N_LINES-1:0];

  always_comb begin
    ien_d_o  = ien_q_o;
    fen_d_o  = fen_q_o;
    soft_d_o = soft_q_o;
    rd_val   = '0;
    rd_bad   = 1'b0;
    wr_bad   = 1'b0;
    case (idx_i)
      IX_IRQ_STAT: begin rd_val = DATA_W'(raw_q_i & ien_q_o); wr_bad = 1'b1; end
      IX_FIQ_STAT: begin rd_val = DATA_W'(raw_q_i & fen_q_o); wr_bad = 1'b1; end
      IX_IRQ_RAW, IX_FIQ_RAW: begin rd_val = DATA_W'(raw_q_i); wr_bad = 1'b1; end
      IX_IRQ_ENS: begin
        rd_val = DATA_W'(ien_q_o);
        if (wr) ien_d_o = ien_q_o | wmask;
      end
      IX_IRQ_ENC: begin
        rd_bad = 1'b1;
        if (wr) ien_d_o = ien_q_o & ~wmask;
      end
      IX_FIQ_ENS: begin
        rd_val = DATA_W'(fen_q_o);
        if (wr) fen_d_o = fen_q_o | wmask;
      end
      IX_FIQ_ENC: begin
        rd_bad = 1'b1;
        if (wr) fen_d_o = fen_q_o & ~wmask;
      end
      IX_SOFT_SET: begin
        rd_val = DATA_W'(raw_q_i[0]);
        if (wr && wdata_i[0]) soft_d_o = 1'b1;
      end
      IX_SOFT_CLR: begin
        rd_bad = 1'b1;
        if (wr && wdata_i[0]) soft_d_o = 1'b0;
      end
      default: begin rd_bad = 1'b1; wr_bad = 1'b1; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q_o  <= '0;
      fen_q_o  <= '0;
      soft_q_o <= 1'b0;
      rdata_o  <= '0;
      err_o    <= 1'b0;
    end else begin
      ien_q_o  <= ien_d_o;
      fen_q_o  <= fen_d_o;
      soft_q_o <= soft_d_o;
      rdata_o  <= (rd && !rd_bad) ? rd_val : '0;
      err_o    <= (rd && rd_bad) || (wr && wr_bad);
    end
  end

  p_mask_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx_i == IX_IRQ_ENS) |=>
      ((ien_q_o & $past(wdata_i[N_LINES-1:0])) == $past(wdata_i[N_LINES-1:0])));

  p_mask_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx_i == IX_IRQ_ENC) |=>
      ((ien_q_o & $past(wdata_i[N_LINES-1:0])) == '0));

  p_soft_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && idx_i == IX_SOFT_SET) |=> (rdata_o[DATA_W-1:1] == '0));

  p_fast_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx_i == IX_FIQ_ENC) |=>
      ((fen_q_o & $past(wdata_i[N_LINES-1:0])) == '0));

  p_status_wr_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (idx_i == IX_IRQ_STAT || idx_i == IX_FIQ_RAW)) |=>
      (err_o && $stable(ien_q_o) && $stable(fen_q_o) && $stable(soft_q_o)));

  p_clr_rd_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && idx_i == IX_IRQ_ENC) |=> (err_o && rdata_o == '0));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!err_o && rdata_o == '0));
endmodule

// File: rtl/dic_out.sv
module dic_out #(
  parameter int N_LINES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] raw_d_i,
  input  logic [N_LINES-1:0] en_d_i,
  output logic               out_o
);
  // Fed from next-state values: output lands on the same edge as its cause.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_o <= 1'b0;
    else         out_o <= |(raw_d_i & en_d_i);
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dic_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] lines_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int PAD_W = N_LINES - 1;

  logic [N_LINES-1:0] line_q, raw_q, raw_d;
  logic [N_LINES-1:0] ien_q, fen_q, ien_d, fen_d;
  logic               soft_q, soft_d;
  logic [N_OUT-1:0][N_LINES-1:0] en_d;
  logic [N_OUT-1:0]   outs;

  dic_capture #(.N_LINES(N_LINES)) i_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lines_i  (lines_i),
    .line_q_o (line_q)
  );

  assign raw_q = line_q  | {{PAD_W{1'b0}}, soft_q};
  assign raw_d = lines_i | {{PAD_W{1'b0}}, soft_d};

  dic_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .idx_i    (idx_i),
    .wdata_i  (wdata_i),
    .raw_q_i  (raw_q),
    .ien_q_o  (ien_q),
    .fen_q_o  (fen_q),
    .ien_d_o  (ien_d),
    .fen_d_o  (fen_d),
    .soft_q_o (soft_q),
    .soft_d_o (soft_d),
    .rdata_o  (rdata_o),
    .err_o    (err_o)
  );

  assign en_d[0] = ien_d;
  assign en_d[1] = fen_d;

  for (genvar c = 0; c < N_OUT; c++) begin : g_out
    dic_out #(.N_LINES(N_LINES)) i_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_d_i (raw_d),
      .en_d_i  (en_d[c]),
      .out_o   (outs[c])
    );
  end

  assign irq_o = outs[0];
  assign fiq_o = outs[1];

  p_irq_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(raw_q & ien_q));

  p_fiq_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == |(raw_q & fen_q));

  p_soft_line0_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(soft_d) && ien_q[0]) |-> irq_o);
endmodule

// File: tb/test_dual_irq_ctrl.sv
module test_dual_irq_ctrl;
  localparam int IW = dic_pkg::IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        err, irq, fiq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit cmp_en = 0;
  string phase = "R1";

  // reference model state
  bit [31:0] m_line, m_ien, m_fen, m_rd, raw;
  bit        m_soft, m_irq, m_fiq, m_err;

  always #5 clk = ~clk;

  dual_irq_ctrl i_dual_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .req_i(req), .we_i(we),
    .idx_i(idx), .wdata_i(wd), .rdata_o(rdata), .err_o(err),
    .irq_o(irq), .fiq_o(fiq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = '0; m_ien = '0; m_fen = '0; m_soft = 0;
      m_irq = 0; m_fiq = 0; m_rd = '0; m_err = 0;
    end else begin
      raw = m_line | {31'b0, m_soft};
      m_rd = '0; m_err = 0;
      if (req && !we) begin
        case (int'(idx))
          0: m_rd = raw & m_ien;
          1, 9: m_rd = raw;
          2: m_rd = m_ien;
          4: m_rd = {31'b0, raw[0]};
          8: m_rd = raw & m_fen;
          10: m_rd = m_fen;
          default: m_err = 1;
        endcase
      end else if (req && we) begin
        case (int'(idx))
          2: m_ien = m_ien | wd;
          3: m_ien = m_ien & ~wd;
          4: if (wd[0]) m_soft = 1;
          5: if (wd[0]) m_soft = 0;
          10: m_fen = m_fen | wd;
          11: m_fen = m_fen & ~wd;
          default: m_err = 1;
        endcase
      end
      m_line = lines;
      raw = m_line | {31'b0, m_soft};
      m_irq = |(raw & m_ien);
      m_fiq = |(raw & m_fen);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", phase, tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) begin
      chk("R8 irq_o", {31'b0, irq}, {31'b0, m_irq});
      chk("R9 fiq_o", {31'b0, fiq}, {31'b0, m_fiq});
      chk("R12 rdata_o", rdata, m_rd);
      chk("R10 err_o", {31'b0, err}, {31'b0, m_err});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R12 actual=%0d expected<%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic acc(input bit w, input int ix, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; idx = IW'(ix); wd = d;
    @(negedge clk);
    req = 0; we = 0; wd = '0;
  endtask

  task automatic wr(input int ix, input logic [31:0] d); acc(1, ix, d); endtask
  task automatic rd(input int ix); acc(0, ix, '0); endtask

  initial begin
    // R1: reset state
    idle(3);
    chk("R1 irq_o", {31'b0, irq}, 32'd0);
    chk("R1 fiq_o", {31'b0, fiq}, 32'd0);
    chk("R1 rdata_o", rdata, 32'd0);
    chk("R1 err_o", {31'b0, err}, 32'd0);
    rst_n = 1;
    cmp_en = 1;
    rd(2); rd(10); rd(4); rd(0);

    phase = "R2";
    lines = 32'hA5A5_0000; idle(1);
    rd(1); rd(9);
    lines = 32'h1234_5678; rd(1);

    phase = "R3";
    wr(2, 32'h0000_FF00); rd(2);
    wr(2, 32'h0000_000F); rd(2);

    phase = "R7";
    rd(0); lines = 32'h0000_0F0F; rd(0); rd(8);

    phase = "R8";
    lines = 32'h0000_0100; idle(2);
    lines = 32'h0; idle(2);
    lines = 32'h0000_0100; idle(1);

    phase = "R4";
    wr(3, 32'h0000_0F00); rd(2); idle(1);
    wr(3, 32'hFFFF_FFFF); rd(2);

    phase = "R5";
    lines = 32'h0;
    wr(4, 32'hFFFF_FFFE); rd(4);
    wr(4, 32'h0000_0001); rd(4); rd(1);
    wr(5, 32'hFFFF_FFFE); rd(4);
    wr(5, 32'h0000_0001); rd(4);

    phase = "R11";
    wr(2, 32'h0000_0001);
    lines = 32'h0000_0001; idle(2);
    wr(4, 32'h1); idle(1);
    lines = 32'h0; idle(2); rd(0);
    wr(5, 32'h1); idle(2); rd(0);

    phase = "R6";
    wr(10, 32'h8000_0001); rd(10);
    wr(11, 32'h0000_0001); rd(10);

    phase = "R9";
    lines = 32'h8000_0000; idle(2); rd(8);
    lines = 32'h0; idle(2);

    phase = "R10";
    rd(3); rd(5); rd(11); rd(6); rd(7); rd(12); rd(15);
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
    wr(8, 32'hFFFF_FFFF); wr(9, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF); wr(13, 32'hFFFF_FFFF);
    rd(2); rd(10); rd(4);

    phase = "R12";
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      req = 1; we = 0; idx = IW'(i); wd = '0;
      @(negedge clk);
    end
    req = 0;
    for (int i = 0; i < 4000; i++) begin
      lines = $urandom;
      req = ($urandom % 3) != 0;
      we = $urandom % 2;
      idx = IW'($urandom % 16);
      wd = $urandom;
      @(negedge clk);
    end
    req = 0; we = 0;
    idle(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule